// File: doc/BRIEF.md
# Pixel Select and Overlay Stage

This stage sits in the pixel pipeline ahead of palette lookup. On every clock it takes one red, green and blue sample and two per-pixel select lines. It returns either the masked pixel or one of three overlay colors, together with an output-enable flag. A per-channel bit mask is applied to the incoming bytes first. A 2-bit mode field then decides how the select lines are interpreted.

In the palette-select mode, several of these stages can share one display. Each stage compares the select lines with its own 2-bit match value, and only the stage that matches drives a color; the others blank. In overlay mode, a nonzero select value replaces the pixel with an overlay color. In ignore mode, the select lines have no effect. The fourth encoding is reserved. It behaves like ignore mode and latches a sticky error flag. Results are registered, so they appear one clock after their inputs.

Top module: `pixel_select_stage`

## Requirements
- R1: Each of redIn, greenIn and blueIn is bitwise ANDed with pixMask before it reaches the output.
- R2: With modeSel = 2'b00 and selIn equal to matchVal, the next cycle shows the masked pixel with outEn = 1.
- R3: With modeSel = 2'b00 and selIn different from matchVal, the next cycle has outEn = 0.
- R4: With modeSel = 2'b10 and selIn = k (k = 1..3), the next cycle shows overlay color k with outEn = 1. Color k sits in ovlColors[24k-1 : 24k-24] as {red[23:16], green[15:8], blue[7:0]}, relative to its slice.
- R5: With modeSel = 2'b10 and selIn = 2'b00, the next cycle shows the masked pixel with outEn = 1.
- R6: With modeSel = 2'b11, selIn has no effect: the next cycle shows the masked pixel with outEn = 1.
- R7: modeSel = 2'b01 is reserved. It produces the same output as R6 and sets illegalMode on the following edge. illegalMode stays set until reset.
- R8: Color outputs and outEn are registered together, exactly one clock after the inputs that produced them.
- R9: Whenever outEn is 0, redOut, greenOut and blueOut are all zero.
- R10: While rstN is low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Active-low synchronous reset |
| redIn | input | 8 | Red pixel sample |
| greenIn | input | 8 | Green pixel sample |
| blueIn | input | 8 | Blue pixel sample |
| selIn | input | 2 | Per-pixel select lines |
| pixMask | input | 8 | Bit mask applied to each channel |
| modeSel | input | 2 | 00 palette select, 01 reserved, 10 overlay, 11 ignore |
| matchVal | input | 2 | Match value for palette-select mode |
| ovlColors | input | 72 | Three packed overlay colors, color 1 in the low 24 bits |
| redOut | output | 8 | Red result |
| greenOut | output | 8 | Green result |
| blueOut | output | 8 | Blue result |
| outEn | output | 1 | Output enable |
| illegalMode | output | 1 | Sticky reserved-mode flag |

## Verification
Each color result and its enable are due exactly one rising edge after the inputs are applied. The sticky flag is also due on that same edge after the first reserved-mode cycle. The bench drives inputs just after a falling edge and computes the expected result from those inputs. It then waits for one rising edge and compares at the following falling edge, so every comparison lands on the cycle the result is due. A held reserved-mode flag is checked on every later cycle until a fresh reset, where it must read zero on the first cycle after reset.

// File: rtl/psel_pkg.sv
package psel_pkg;
  localparam int SEL_W = 2;

  typedef enum logic [SEL_W-1:0] {
    MODE_PSEL = 2'b00,
    MODE_RSVD = 2'b01,
    MODE_OVL  = 2'b10,
    MODE_IGN  = 2'b11
  } mode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic             blank;
    logic             useOvl;
    logic [SEL_W-1:0] ovlIdx;
  } strobe_t;
endpackage

// File: rtl/psel_ctrl.sv
module psel_ctrl
  import psel_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [SEL_W-1:0] modeSel,
  input  logic [SEL_W-1:0] selIn,
  input  logic [SEL_W-1:0] matchVal,
  output strobe_t          strobe,
  output logic             illegalMode
);
  always_comb begin
    strobe = '0;
    unique case (mode_e'(modeSel))
      MODE_PSEL: strobe.blank = (selIn != matchVal);
      MODE_OVL: begin
        strobe.useOvl = (selIn != '0);
        strobe.ovlIdx = selIn;
      end
      default: ; // ignore and reserved pass the masked pixel
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)                          illegalMode <= 1'b0;
    else if (mode_e'(modeSel) == MODE_RSVD) illegalMode <= 1'b1;
  end
endmodule

// File: rtl/psel_datapath.sv
module psel_datapath
  import psel_pkg::*;
#(
  parameter int PIX_W   = 8,
  parameter int NUM_OVL = 3
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [3*PIX_W-1:0]         pixIn,
  input  logic [PIX_W-1:0]           pixMask,
  input  logic [NUM_OVL*3*PIX_W-1:0] ovlColors,
  input  strobe_t                    strobe,
  output logic [3*PIX_W-1:0]         pixOut,
  output logic                       outEn
);
  localparam int COL_W = 3 * PIX_W;

  logic [COL_W-1:0] maskedPix;
  logic [COL_W-1:0] ovlPick;
  logic [COL_W-1:0] nextPix;

  for (genvar ch = 0; ch < 3; ch++) begin : g_mask
    assign maskedPix[ch*PIX_W +: PIX_W] = pixIn[ch*PIX_W +: PIX_W] & pixMask;
  end

  always_comb begin
    ovlPick = '0;
    for (int k = 0; k < NUM_OVL; k++) begin
      if (strobe.ovlIdx == SEL_W'(k + 1)) ovlPick = ovlColors[k*COL_W +: COL_W];
    end
  end

  always_comb begin
    if (strobe.blank)       nextPix = '0;
    else if (strobe.useOvl) nextPix = ovlPick;
    else                    nextPix = maskedPix;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pixOut <= '0;
      outEn  <= 1'b0;
    end else begin
      pixOut <= nextPix;
      outEn  <= !strobe.blank;
    end
  end
endmodule

// File: rtl/pixel_select_stage.sv
module pixel_select_stage
  import psel_pkg::*;
#(
  parameter int PIX_W = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [PIX_W-1:0]     redIn,
  input  logic [PIX_W-1:0]     greenIn,
  input  logic [PIX_W-1:0]     blueIn,
  input  logic [1:0]           selIn,
  input  logic [PIX_W-1:0]     pixMask,
  input  logic [1:0]           modeSel,
  input  logic [1:0]           matchVal,
  input  logic [9*PIX_W-1:0]   ovlColors,
  output logic [PIX_W-1:0]     redOut,
  output logic [PIX_W-1:0]     greenOut,
  output logic [PIX_W-1:0]     blueOut,
  output logic                 outEn,
  output logic                 illegalMode
);
  localparam int NUM_OVL = (1 << SEL_W) - 1;

  strobe_t           strobe;
  logic [3*PIX_W-1:0] pixOut;

  psel_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .modeSel     (modeSel),
    .selIn       (selIn),
    .matchVal    (matchVal),
    .strobe      (strobe),
    .illegalMode (illegalMode)
  );

  psel_datapath #(.PIX_W(PIX_W), .NUM_OVL(NUM_OVL)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .pixIn     ({redIn, greenIn, blueIn}),
    .pixMask   (pixMask),
    .ovlColors (ovlColors),
    .strobe    (strobe),
    .pixOut    (pixOut),
    .outEn     (outEn)
  );

  assign {redOut, greenOut, blueOut} = pixOut;
endmodule

// File: rtl/pixel_select_stage_chk.sv
module pixel_select_stage_chk #(
  parameter int PIX_W = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic [PIX_W-1:0]   redIn,
  input logic [PIX_W-1:0]   greenIn,
  input logic [PIX_W-1:0]   blueIn,
  input logic [1:0]         selIn,
  input logic [PIX_W-1:0]   pixMask,
  input logic [1:0]         modeSel,
  input logic [1:0]         matchVal,
  input logic [9*PIX_W-1:0] ovlColors,
  input logic [PIX_W-1:0]   redOut,
  input logic [PIX_W-1:0]   greenOut,
  input logic [PIX_W-1:0]   blueOut,
  input logic               outEn,
  input logic               illegalMode
);
  localparam int COL_W = 3 * PIX_W;
  logic [COL_W-1:0] inMasked;
  logic [COL_W-1:0] outCol;
  logic [COL_W-1:0] ovlWant;

  assign inMasked = {redIn & pixMask, greenIn & pixMask, blueIn & pixMask};
  assign outCol   = {redOut, greenOut, blueOut};
  always_comb begin
    ovlWant = '0;
    if (selIn != 2'b00) ovlWant = ovlColors[(int'(selIn) - 1)*COL_W +: COL_W];
  end

  p_psel_match_r2: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == 2'b00 && selIn == matchVal) |=> (outEn && outCol == $past(inMasked)));
  p_psel_miss_r3: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == 2'b00 && selIn != matchVal) |=> !outEn);
  p_ovl_pick_r4: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == 2'b10 && selIn != 2'b00) |=> (outEn && outCol == $past(ovlWant)));
  p_ovl_pass_r5: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == 2'b10 && selIn == 2'b00) |=> (outEn && outCol == $past(inMasked)));
  p_ignore_r6: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == 2'b11) |=> (outEn && outCol == $past(inMasked)));
  p_rsvd_flag_r7: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == 2'b01) |=> (illegalMode && outEn));
  p_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    illegalMode |=> illegalMode);
  p_blank_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    !outEn |-> (outCol == '0));
  p_reset_r10: assert property (@(posedge clk)
    !rstN |=> (!outEn && outCol == '0 && !illegalMode));
endmodule

bind pixel_select_stage pixel_select_stage_chk #(.PIX_W(PIX_W)) u_chk (.*);

// File: tb/pixel_select_stage_tb.sv
`timescale 1ns/1ps
module pixel_select_stage_tb;
  logic        clk = 1'b0;
  logic        rstN;
  logic [7:0]  redIn, greenIn, blueIn, pixMask;
  logic [1:0]  selIn, modeSel, matchVal;
  logic [71:0] ovlColors;
  logic [7:0]  redOut, greenOut, blueOut;
  logic        outEn, illegalMode;

  int checks = 0;
  int errors = 0;
  logic [23:0] expCol;
  logic        expEn;
  logic        expIll = 1'b0;
  string       tag;

  always #4 clk = ~clk;

  pixel_select_stage u_dut (.*);

  task automatic check(input string t, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", t, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // behavioural reference: one pixel in, one expected result out
  task automatic step(input logic [1:0] m, input logic [1:0] s, input logic [1:0] mv,
                      input logic [7:0] r, input logic [7:0] g, input logic [7:0] b,
                      input logic [7:0] mk);
    logic [23:0] masked;
    modeSel = m; selIn = s; matchVal = mv;
    redIn = r; greenIn = g; blueIn = b; pixMask = mk;
    masked = {r & mk, g & mk, b & mk};
    case (m)
      2'b00: if (s == mv) begin expEn = 1; expCol = masked; tag = "R2 R1"; end
             else begin expEn = 0; expCol = 24'h0; tag = "R3 R9"; end
      2'b10: if (s == 2'b00) begin expEn = 1; expCol = masked; tag = "R5 R1"; end
             else begin expEn = 1; expCol = ovlColors[(int'(s) - 1)*24 +: 24]; tag = "R4"; end
      2'b11: begin expEn = 1; expCol = masked; tag = "R6 R1"; end
      default: begin expEn = 1; expCol = masked; tag = "R7"; expIll = 1'b1; end
    endcase
    @(posedge clk);
    @(negedge clk);
    check({tag, " R8 color"}, {8'h0, redOut, greenOut, blueOut}, {8'h0, expCol});
    check({tag, " R8 enable"}, {31'h0, outEn}, {31'h0, expEn});
    check("R7 flag", {31'h0, illegalMode}, {31'h0, expIll});
  endtask

  task automatic do_reset();
    rstN = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R10 color", {8'h0, redOut, greenOut, blueOut}, 32'h0);
    check("R10 enable", {31'h0, outEn}, 32'h0);
    check("R10 flag", {31'h0, illegalMode}, 32'h0);
    expIll = 1'b0;
    rstN = 1'b1;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rstN = 1'b0; redIn = 8'h12; greenIn = 8'h34; blueIn = 8'h56; pixMask = 8'hFF;
    selIn = 2'b01; modeSel = 2'b11; matchVal = 2'b00;
    ovlColors = {24'hC0FFEE, 24'h00A5B6, 24'h7F1122};
    @(negedge clk);
    do_reset();

    // palette select: match and mismatch, several match values
    step(2'b00, 2'b00, 2'b00, 8'hA5, 8'h5A, 8'hFF, 8'hFF);
    step(2'b00, 2'b01, 2'b00, 8'hA5, 8'h5A, 8'hFF, 8'hFF);
    step(2'b00, 2'b11, 2'b11, 8'h81, 8'h42, 8'h24, 8'h0F);
    step(2'b00, 2'b10, 2'b01, 8'hFF, 8'hFF, 8'hFF, 8'hFF);
    // overlay: each select value
    for (int s = 0; s < 4; s++) step(2'b10, 2'(s), 2'b00, 8'h9C, 8'h3E, 8'hD1, 8'hF0);
    // ignore mode with every select value and mask extremes (R6, R1)
    for (int s = 0; s < 4; s++) step(2'b11, 2'(s), 2'(3 - s), 8'hEE, 8'h77, 8'h11, 8'h00);
    step(2'b11, 2'b10, 2'b00, 8'hEE, 8'h77, 8'h11, 8'hFF);
    // mismatch then match back-to-back (R8 latency)
    step(2'b00, 2'b01, 2'b10, 8'h10, 8'h20, 8'h30, 8'hFF);
    step(2'b00, 2'b10, 2'b10, 8'h10, 8'h20, 8'h30, 8'hFF);

    // random traffic in the legal modes
    for (int i = 0; i < 300; i++) begin
      logic [1:0] m;
      m = 2'($urandom_range(0, 2));
      if (m == 2'b01) m = 2'b11;
      step(m, 2'($urandom), 2'($urandom), 8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom));
    end

    // reserved mode: flag rises and sticks across legal traffic (R7)
    step(2'b01, 2'b10, 2'b00, 8'h5F, 8'hA0, 8'h3C, 8'hFF);
    step(2'b00, 2'b00, 2'b00, 8'h01, 8'h02, 8'h03, 8'hFF);
    step(2'b10, 2'b11, 2'b00, 8'h01, 8'h02, 8'h03, 8'hFF);
    for (int i = 0; i < 20; i++)
      step(2'b11, 2'($urandom), 2'b00, 8'($urandom), 8'($urandom), 8'($urandom), 8'hFF);

    // reset clears the flag (R10)
    @(negedge clk);
    do_reset();
    step(2'b11, 2'b00, 2'b00, 8'h44, 8'h55, 8'h66, 8'hFF);

    finish_run();
  end
endmodule